// File: doc/BRIEF.md
# Quadrature Position Decoder with Edge-Interval Timer

This block turns two phase-shifted encoder channels and a once-per-revolution marker into a signed-direction position count. Every level change on either channel moves the count by one (four counts per encoder line). The count moves up or down according to which channel leads. The count wraps between zero and a programmable top value, and the marker clears it. An interval timer measures the clock cycles between valid channel edges, which lets software derive speed.

Five event sources latch into sticky status bits: count wrap or marker, marker error, phase error, timer overflow and timer capture. Each bit has a mask bit, and the block drives a single interrupt line. A small register port gives access to the top value, the mask, the status and the last captured interval. The current count is a separate output.

Top module: `quad_tacho`

## Requirements
- R1: Each encoder input passes through two flip-flops. A single-channel change on the synchronised pair, in the order AB = 00→10→11→01→00, raises `position` by one. The new value appears after the third rising clock edge after the pin change.
- R2: A single-channel change in the opposite order (00→01→11→10→00) lowers `position` by one.
- R3: If both channels change in the same synchronised sample, it is a phase error. `position` is unchanged, status bit 2 sets, and no interval capture takes place.
- R4: Counting up from the top value gives 0, and counting down from 0 gives the top value. Either wrap sets status bit 0. The top value is at address 0 and resets to all ones.
- R5: A rising edge on the synchronised marker input clears `position` to 0 and sets status bit 0. It takes precedence over a channel step in the same sample.
- R6: When the marker rises while `position` is neither 0 nor the top value, status bit 1 sets. At 0 or at the top value it does not.
- R7: On each valid single-channel step, the interval timer value is captured and readable at address 3. The timer then restarts at 1, so the captured value equals the clock cycles since the previous step. Status bit 4 sets.
- R8: When the interval timer is all ones and no step occurs, it wraps to 0 and status bit 3 sets.
- R9: Register map (2-bit address, combinational read): 0 top value, 1 mask (5 bits, reset 0, upper bits read 0), 2 status, 3 captured interval (read only).
- R10: Status bits are sticky. Writing 1 to a bit at address 2 clears it, and writing 0 leaves it unchanged. `irq` is high exactly when some status bit and its mask bit are both 1.
- R11: After reset, `position` is 0, status is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder channel A (asynchronous) |
| enc_b | input | 1 | Encoder channel B (asynchronous) |
| enc_idx | input | 1 | Once-per-turn marker (asynchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | PW | Register write data |
| reg_rdata | output | PW | Register read data |
| position | output | PW | Current position count |
| irq | output | 1 | Masked OR of status bits |

## Verification
The assertions assume that the encoder pins are low through reset. They also assume that each pin change is held long enough for the synchroniser to see it, so that a decoded step and the sample before it are adjacent states. The stimulus holds the pins low during reset and changes them only at falling clock edges, at least four cycles apart. A phase error is produced only on purpose, by changing both channels at the same falling edge. The overflow case is reached by leaving the pins idle for longer than the timer range of the bench's reduced timer width.

// File: rtl/quad_tacho.sv
module quad_tacho #(
  parameter int PW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          enc_idx,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [PW-1:0] reg_wdata,
  output logic [PW-1:0] reg_rdata,
  output logic [PW-1:0] position,
  output logic          irq
);
  localparam int NS = 5;
  localparam logic [1:0] A_TOP = 2'd0, A_MSK = 2'd1, A_STS = 2'd2, A_CAP = 2'd3;

  logic [1:0]    a_sy, b_sy, z_sy;
  logic          a_q, b_q, z_q;
  logic [PW-1:0] pos_q, top_q;
  logic [TW-1:0] tmr_q, cap_q;
  logic [NS-1:0] st_q, msk_q, st_set, st_clr;

  wire a_s = a_sy[1];
  wire b_s = b_sy[1];
  wire z_s = z_sy[1];
  wire a_chg = a_s ^ a_q;
  wire b_chg = b_s ^ b_q;
  wire step  = a_chg ^ b_chg;
  wire perr  = a_chg & b_chg;
  wire up    = a_s ^ b_q;
  wire z_rise  = z_s & ~z_q;
  wire at_top  = (pos_q == top_q);
  wire at_zero = (pos_q == '0);
  wire wrap    = step & ~z_rise & (up ? at_top : at_zero);
  wire idx_err = z_rise & ~at_zero & ~at_top;
  wire t_ovf   = ~step & (&tmr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sy <= '0; b_sy <= '0; z_sy <= '0;
      a_q <= 1'b0; b_q <= 1'b0; z_q <= 1'b0;
    end else begin
      a_sy <= {a_sy[0], enc_a};
      b_sy <= {b_sy[0], enc_b};
      z_sy <= {z_sy[0], enc_idx};
      a_q <= a_s; b_q <= b_s; z_q <= z_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pos_q <= '0;
    else if (z_rise)
      pos_q <= '0;
    else if (step) begin
      if (up) pos_q <= at_top ? '0 : pos_q + PW'(1);
      else    pos_q <= at_zero ? top_q : pos_q - PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
      cap_q <= '0;
    end else if (step) begin
      cap_q <= tmr_q;
      tmr_q <= TW'(1);
    end else begin
      tmr_q <= tmr_q + TW'(1);
    end
  end

  assign st_set = {step, t_ovf, perr, idx_err, wrap | z_rise};
  assign st_clr = (reg_we && reg_addr == A_STS) ? reg_wdata[NS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      msk_q <= '0;
      top_q <= '1;
    end else begin
      st_q <= (st_q & ~st_clr) | st_set;
      if (reg_we && reg_addr == A_MSK) msk_q <= reg_wdata[NS-1:0];
      if (reg_we && reg_addr == A_TOP) top_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_TOP:   reg_rdata = top_q;
      A_MSK:   reg_rdata = PW'(msk_q);
      A_STS:   reg_rdata = PW'(st_q);
      default: reg_rdata = PW'(cap_q);
    endcase
  end

  assign position = pos_q;
  assign irq = |(st_q & msk_q);

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !z_rise) |=> ($stable(position) && st_q[2]));

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && up && !z_rise && !at_top) |=> (position == $past(position) + PW'(1)));

  // R5
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z_rise |=> (position == '0 && st_q[0]));

  // R7
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (tmr_q == TW'(1) && st_q[4]));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_STS) |=> ((st_q & $past(st_q)) == $past(st_q)));
endmodule

// File: tb/quad_tacho_test.sv
`timescale 1ns/1ps
module quad_tacho_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0, reg_rdata, position;
  logic irq;
  int nvec = 0, nbad = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  quad_tacho #(.PW(16), .TW(10)) uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .position(position), .irq(irq));

  // {a, b, idx, expected position}
  localparam logic [18:0] VEC [0:15] = '{
    {3'b100, 16'h0001}, {3'b110, 16'h0002}, {3'b010, 16'h0003}, {3'b000, 16'h0004},
    {3'b100, 16'h0005}, {3'b000, 16'h0004}, {3'b010, 16'h0003}, {3'b110, 16'h0002},
    {3'b100, 16'h0001}, {3'b000, 16'h0000}, {3'b010, 16'hFFFF}, {3'b000, 16'h0000},
    {3'b110, 16'h0000}, {3'b010, 16'h0001}, {3'b001, 16'h0000}, {3'b000, 16'h0000}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b, input logic z, input int gap);
    @(negedge clk);
    enc_a = a; enc_b = b; enc_idx = z;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] ad, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ad, output logic [15:0] d);
    reg_addr = ad;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 position", position, 16'h0000);
    check("R11 irq", {15'd0, irq}, 16'h0000);
    rd(2'd2, rv); check("R11 status", rv, 16'h0000);
    rd(2'd0, rv); check("R4 top reset", rv, 16'hFFFF);

    // R1 R2 R3 R4 R5 table walk
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][18], VEC[i][17], VEC[i][16], 4);
      check($sformatf("R1/R2 vector %0d", i), position, VEC[i][15:0]);
    end
    rd(2'd2, rv); check("R3 R6 status after table", rv, 16'h0017);
    check("R10 irq masked off", {15'd0, irq}, 16'h0000);
    wr(2'd1, 16'h0004); check("R10 irq phase mask", {15'd0, irq}, 16'h0001);
    wr(2'd2, 16'h0000); rd(2'd2, rv); check("R10 write zero keeps", rv, 16'h0017);
    wr(2'd2, 16'h0004); rd(2'd2, rv); check("R10 w1c", rv, 16'h0013);
    check("R10 irq cleared", {15'd0, irq}, 16'h0000);
    wr(2'd1, 16'hFFFF); rd(2'd1, rv); check("R9 mask width", rv, 16'h001F);
    wr(2'd1, 16'h0000);

    // R4 R5 R6 with top value 5
    wr(2'd0, 16'h0005); wr(2'd2, 16'h001F);
    drive(1,0,0,4); drive(1,1,0,4); drive(0,1,0,4); drive(0,0,0,4); drive(1,0,0,4);
    check("R1 count to top", position, 16'h0005);
    drive(1,0,1,4);
    check("R5 index clears", position, 16'h0000);
    rd(2'd2, rv); check("R6 no error at top", rv & 16'h0003, 16'h0001);
    drive(1,0,0,4); wr(2'd2, 16'h001F);
    drive(1,1,0,4); drive(0,1,0,4);
    check("R1 count 2", position, 16'h0002);
    drive(0,1,1,4);
    rd(2'd2, rv); check("R6 index error", rv & 16'h0003, 16'h0003);
    drive(0,1,0,4); wr(2'd2, 16'h001F);
    drive(1,1,0,4);
    check("R4 down wrap to top", position, 16'h0005);
    rd(2'd2, rv); check("R4 wrap flag down", rv & 16'h0001, 16'h0001);
    wr(2'd2, 16'h001F);
    drive(0,1,0,4);
    check("R4 up wrap to zero", position, 16'h0000);
    rd(2'd2, rv); check("R4 wrap flag up", rv & 16'h0001, 16'h0001);

    // R7 capture interval
    drive(0,0,0,9); drive(1,0,0,9);
    rd(2'd3, rv); check("R7 captured interval", rv, 16'd9);
    rd(2'd2, rv); check("R7 capture flag", rv & 16'h0010, 16'h0010);

    // R8 overflow
    wr(2'd2, 16'h001F);
    repeat (1100) @(negedge clk);
    rd(2'd2, rv); check("R8 overflow flag", rv & 16'h0008, 16'h0008);
    wr(2'd1, 16'h0008); check("R8 irq on overflow", {15'd0, irq}, 16'h0001);
    wr(2'd2, 16'h0008); check("R10 irq after clear", {15'd0, irq}, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule